// File: doc/BRIEF.md
# Hot-Plug Interrupt and GPIO Controller

This block sits behind a simple parallel register port and owns one 8-bit control word. The word drives three things: a shared status/clock pin, a detector for the hot-plug input, and two bidirectional general-purpose pins. The shared pin does one of two jobs. It can act as an open-drain interrupt line that is pulled low once the hot-plug input changes level. It can instead act as a push-pull output that forwards a reference clock, with the polarity selected in the control word. When neither job is active, the pin floats.

A small state machine runs the interrupt. DISARMED is the idle state and is used while the interrupt is off. The machine moves DISARMED to ARMED when the enable bit is set and the clear bit is low. It moves ARMED to PENDING on any change of the synchronized hot-plug level. It moves ARMED to DISARMED when the enable is dropped. It moves ARMED or PENDING to CLEARING while the clear bit is high. It leaves CLEARING when the clear bit falls: to ARMED if the enable is still set, otherwise to DISARMED. Software handles an interrupt by setting the clear bit and then clearing it again.

The two general-purpose pins are inputs after reset. Each pin has a direction bit and a level bit. An output pin drives its stored level. An input pin is synchronized through two flops, and a read returns the sampled level.

Top module: `hpg_ctrl`

## Requirements
- R1: The control word is at address 0x1E and resets to 0xC0. A write to 0x1E stores the write data. A read at any other address returns 0, and a write to any other address leaves the word unchanged.
- R2: Bit 6 sets the direction of GPIO0 and bit 7 sets the direction of GPIO1. A value of 1 makes the pin an input (its output enable is low). A value of 0 makes it an output.
- R3: Bit 4 holds the level of GPIO0 and bit 5 holds the level of GPIO1. For an output pin, the stored bit drives the pin, and a read returns the stored bit.
- R4: For an input pin, a read returns the pin level after a two-flop synchronizer. Writing the level bit does not change what a read returns.
- R5: Clock mode applies when bit 1 is 1, bit 2 is 0 and no interrupt is pending. In clock mode the shared pin is enabled and carries the reference clock XOR bit 0.
- R6: When bits 1 and 2 are both 0 and no interrupt is pending, the shared pin is released (output enable low).
- R7: While bit 2 is 1 and bit 3 is 0, a rising or falling change of the hot-plug input latches a pending interrupt. While an interrupt is pending, the shared pin is enabled and driven low.
- R8: A pending interrupt stays latched until bit 3 is set. While bit 3 is 1, the pin is released. After bit 3 returns to 0, detection is armed again.
- R9: Hot-plug changes that happen while bit 2 is 0 or bit 3 is 1 are never latched.
- R10: When bits 1 and 2 are both set, the interrupt function wins. With no interrupt pending the pin is released, and the clock is never driven.
- R11: A pending interrupt keeps the pin low even if bit 2 is cleared later. Only bit 3 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hpd_in | input | 1 | Asynchronous hot-plug detect level |
| ref_clk_in | input | 1 | Clock forwarded to the shared pin |
| share_oe | output | 1 | Shared pin output enable |
| share_do | output | 1 | Shared pin output data |
| gpio_in | input | 2 | Levels sampled from the GPIO pads |
| gpio_oe | output | 2 | GPIO output enables |
| gpio_do | output | 2 | GPIO output data |

## Verification
The assertions assume that the hot-plug input and the GPIO pad levels reach the block only through its synchronizers. They also assume that software does not expect clock output while the interrupt is enabled, so the shared pin can be driven high only in clock mode. The bench drives every asynchronous input away from the clock edge. Before it checks a level or a pin, it holds the input steady for several cycles so that each change has passed fully through the synchronizer. The random phase keeps the interrupt and clear bits at 0 so that it exercises only the GPIO and clock paths. The directed cases then cover every state of the interrupt state machine.

// File: rtl/hpg_pkg.sv
package hpg_pkg;
    localparam int CTRL_W = 8;
    localparam int GPIO_N = 2;
    localparam int B_POL  = 0;
    localparam int B_CKEN = 1;
    localparam int B_IEN  = 2;
    localparam int B_IRST = 3;
    localparam int B_LVL0 = 4;
    localparam int B_DIR0 = 6;
    localparam logic [CTRL_W-1:0] CTRL_RST = 8'hC0;

    typedef enum logic [1:0] {
        HP_DISARMED = 2'd0,
        HP_ARMED    = 2'd1,
        HP_PENDING  = 2'd2,
        HP_CLEARING = 2'd3
    } hp_state_e;
endpackage

// File: rtl/hpg_sync.sv
module hpg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hpg_regfile.sv
module hpg_regfile
    import hpg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic [GPIO_N-1:0] gpio_sync,
    output logic [CTRL_W-1:0] ctrl,
    output logic [CTRL_W-1:0] rdata
);
    logic              hit;
    logic [CTRL_W-1:0] rd_word;

    assign hit = (addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            ctrl <= CTRL_RST;
        else if (wr_en && hit) ctrl <= wdata;
    end

    always_comb begin
        rd_word = ctrl;
        for (int i = 0; i < GPIO_N; i++) begin
            if (ctrl[B_DIR0+i]) rd_word[B_LVL0+i] = gpio_sync[i];
        end
    end

    assign rdata = hit ? rd_word : '0;

    // R1: a write that hits the address lands in the word on the next edge
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (ctrl == $past(wdata)));

    // R1: a write to any other address leaves the word unchanged
    a_r1_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(ctrl));
endmodule

// File: rtl/hpg_hpd_fsm.sv
module hpg_hpd_fsm
    import hpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hpd_sync,
    input  logic ien,
    input  logic irst,
    input  logic cken,
    input  logic pol,
    input  logic clk_src,
    output logic pin_oe,
    output logic pin_do
);
    hp_state_e state, nxt;
    logic      hpd_prev;
    logic      change;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hpd_prev <= 1'b0;
        else        hpd_prev <= hpd_sync;
    end

    assign change = hpd_sync ^ hpd_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HP_DISARMED;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            HP_DISARMED: if (ien && !irst) nxt = HP_ARMED;
            HP_ARMED: begin
                if (irst)        nxt = HP_CLEARING;
                else if (!ien)   nxt = HP_DISARMED;
                else if (change) nxt = HP_PENDING;
            end
            HP_PENDING:  if (irst) nxt = HP_CLEARING;
            HP_CLEARING: if (!irst) nxt = ien ? HP_ARMED : HP_DISARMED;
            default:     nxt = HP_DISARMED;
        endcase
    end

    // output logic for the shared pin
    always_comb begin
        pin_oe = 1'b0;
        pin_do = 1'b0;
        if (state == HP_PENDING) begin
            pin_oe = 1'b1;
            pin_do = 1'b0;
        end else if (!ien && cken) begin
            pin_oe = 1'b1;
            pin_do = clk_src ^ pol;
        end
    end

    // R7: an armed detector latches a change on the next edge
    a_r7_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HP_ARMED && ien && !irst && change) |=> (state == HP_PENDING));

    // R8 / R11: the latch holds until the clear bit is raised
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HP_PENDING && !irst) |=> (state == HP_PENDING));

    // R8: the clear bit always removes the pending latch
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        irst |=> (state != HP_PENDING));

    // R9: no latch can be taken from the disarmed or clearing states
    a_r9_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HP_DISARMED || state == HP_CLEARING) |=> (state != HP_PENDING));
endmodule

// File: rtl/hpg_ctrl.sv
module hpg_ctrl
    import hpg_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h1E,
    parameter int               SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              hpd_in,
    input  logic              ref_clk_in,
    output logic              share_oe,
    output logic              share_do,
    input  logic [GPIO_N-1:0] gpio_in,
    output logic [GPIO_N-1:0] gpio_oe,
    output logic [GPIO_N-1:0] gpio_do
);
    logic [CTRL_W-1:0] ctrl;
    logic [GPIO_N-1:0] gpio_s;
    logic              hpd_s;

    hpg_sync #(.WIDTH(1), .STAGES(SYNC_N)) u_hpd_sync (
        .clk(clk), .rst_n(rst_n), .d(hpd_in), .q(hpd_s)
    );

    hpg_sync #(.WIDTH(GPIO_N), .STAGES(SYNC_N)) u_gpio_sync (
        .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_s)
    );

    hpg_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .gpio_sync(gpio_s), .ctrl(ctrl), .rdata(reg_rdata)
    );

    hpg_hpd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hpd_sync(hpd_s),
        .ien(ctrl[B_IEN]), .irst(ctrl[B_IRST]), .cken(ctrl[B_CKEN]),
        .pol(ctrl[B_POL]), .clk_src(ref_clk_in),
        .pin_oe(share_oe), .pin_do(share_do)
    );

    generate
        for (genvar i = 0; i < GPIO_N; i++) begin : g_gpio
            assign gpio_oe[i] = ~ctrl[B_DIR0+i];
            assign gpio_do[i] = ctrl[B_LVL0+i];
        end
    endgenerate

    // R10: a high level on the shared pin comes only from clock mode
    a_r10_no_clock_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (share_oe && share_do) |-> (ctrl[B_CKEN] && !ctrl[B_IEN]));

    // R6: with both functions off, the pin never drives high
    a_r6_idle_not_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[B_CKEN] && !ctrl[B_IEN]) |-> !(share_oe && share_do));
endmodule

// File: tb/tb_hpg_ctrl.sv
module tb_hpg_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h1E;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       hpd_in = 1'b0;
    logic       ref_clk_in = 1'b0;
    logic       share_oe, share_do;
    logic [1:0] gpio_in = 2'b00;
    logic [1:0] gpio_oe, gpio_do;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hpg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hpd_in(hpd_in),
        .ref_clk_in(ref_clk_in), .share_oe(share_oe), .share_do(share_do),
        .gpio_in(gpio_in), .gpio_oe(gpio_oe), .gpio_do(gpio_do)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] c, input logic [1:0] g);
        logic [7:0] r = c;
        for (int i = 0; i < 2; i++) if (c[6+i]) r[4+i] = g[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h1E;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin(input string req, input logic oe, input logic d);
        check(req, {6'd0, share_oe, share_do}, {6'd0, oe, d});
    endtask

    initial begin
        logic [7:0] m;
        logic [1:0] g;
        void'($urandom(32'h5EED));
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 reset value", reg_rdata, 8'hC0);
        check("R2 reset dirs", {6'd0, gpio_oe}, 8'h00);
        pin("R6 reset pin", 1'b0, 1'b0);

        // R1 other address
        wr(8'h1D, 8'h55);
        reg_addr = 8'h1D;
        #1 check("R1 foreign read", reg_rdata, 8'h00);
        reg_addr = 8'h1E;
        #1 check("R1 foreign write ignored", reg_rdata, 8'hC0);

        // R2/R3/R4/R5/R6 random phase
        for (int k = 0; k < 60; k++) begin
            m = 8'($urandom) & 8'hF3;
            g = 2'($urandom);
            wr(8'h1E, m);
            gpio_in = g;
            ref_clk_in = 1'($urandom);
            idle(3);
            check("R3/R4 readback", reg_rdata, exp_read(m, g));
            check("R2 direction", {6'd0, gpio_oe}, {6'd0, ~m[7:6]});
            check("R3 drive", {6'd0, gpio_do}, {6'd0, m[5:4]});
            if (m[1]) pin("R5 clock mode", 1'b1, ref_clk_in ^ m[0]);
            else      pin("R6 released", 1'b0, 1'b0);
        end

        // R4 write does not alter input readback
        gpio_in = 2'b10;
        wr(8'h1E, 8'hC0);
        idle(3);
        wr(8'h1E, 8'hF0);
        idle(1);
        check("R4 input level not overwritten", reg_rdata, 8'hE0);

        // R7 rising change
        hpd_in = 1'b0;
        wr(8'h1E, 8'hC4);
        idle(4);
        pin("R7 armed quiet", 1'b0, 1'b0);
        hpd_in = 1'b1;
        idle(5);
        pin("R7 rise latched", 1'b1, 1'b0);
        hpd_in = 1'b0;
        idle(8);
        pin("R8 still pending", 1'b1, 1'b0);

        // R8 clear, R9 changes during clear ignored
        wr(8'h1E, 8'hCC);
        idle(2);
        pin("R8 released by clear", 1'b0, 1'b0);
        hpd_in = 1'b1;
        idle(5);
        pin("R9 no latch while clearing", 1'b0, 1'b0);
        wr(8'h1E, 8'hC4);
        idle(5);
        pin("R8 rearmed quiet", 1'b0, 1'b0);
        hpd_in = 1'b0;
        idle(5);
        pin("R7 fall latched", 1'b1, 1'b0);
        wr(8'h1E, 8'hCC);
        wr(8'h1E, 8'hC0);

        // R9 disabled
        hpd_in = 1'b1;
        idle(5);
        wr(8'h1E, 8'hC4);
        idle(5);
        pin("R9 no latch while disabled", 1'b0, 1'b0);

        // R10 both enables
        ref_clk_in = 1'b1;
        wr(8'h1E, 8'hC6);
        idle(3);
        pin("R10 both enables released", 1'b0, 1'b0);
        hpd_in = 1'b0;
        idle(5);
        pin("R10 irq wins", 1'b1, 1'b0);

        // R11 pending survives disable
        wr(8'h1E, 8'hC2);
        idle(3);
        pin("R11 pending after disable", 1'b1, 1'b0);
        wr(8'h1E, 8'hCA);
        idle(2);
        pin("R11 cleared gives clock", 1'b1, 1'b1);
        wr(8'h1E, 8'hC3);
        idle(2);
        pin("R5 inverted clock", 1'b1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule